// File: doc/BRIEF.md
# Mask-Selected GPIO Bank Registers

This block is the register file of one general-purpose I/O bank of up to 32 lines, reached over a plain memory-mapped bus. The bus has a word address, a write strobe, write data and combinational read data. Each line keeps its own configuration word: peripheral function, direction, pull enables, input filter enables, open-drain and Schmitt control, and an event-type field that a separate interrupt block decodes. All configuration words are reached through one shared configuration window. A line-select mask register decides which lines a configuration write changes, and which line a configuration read reports.

Output levels are changed through write-one-to-set and write-one-to-clear registers, so software never has to read and modify the output latch. The output latch can be read back. The pad input levels are synchronised by two flops and can be read back as one word. The bank drives a pad only when that line is a GPIO output. Banks are meant to be stacked at a 0x40-byte stride, so the bus address of one bank is six bits wide.

Top module: `gpb_bank`

## Requirements
- R1: After reset, the mask, the output latch and every configuration word are zero, and `pad_oe` is all zero.
- R2: Writing offset 0x00 loads the line-select mask, which reads back at 0x00. A write to offset 0x04 updates the configuration of exactly the lines whose mask bit is 1. All other lines keep their configuration.
- R3: Configuration word fields are: function at [2:0] (0 = GPIO, 1..7 = peripheral), direction at bit 8 (1 = output), pull-up at 9, pull-down at 10, input filter at 12, slow-clock filter at 13, open-drain at 14, Schmitt control at 15, and event type at [26:24]. All other bits read 0.
- R4: A write to offset 0x10 sets the output latch bits written as 1, and a write to offset 0x14 clears them. Bits written as 0 are unchanged, and the latch changes only on these writes.
- R5: Offset 0x18 returns the output latch, and `pad_out` equals the latch.
- R6: A read of offset 0x04 returns the configuration of the lowest-numbered line whose mask bit is 1. With a zero mask it returns 0.
- R7: Offset 0x08 returns `pad_in` as it was two clock edges earlier: a change is not visible after one edge and is visible after two.
- R8: `pad_oe[i]` is 1 exactly when line i has direction 1 and function 0.
- R9: Offset 0x0C and unmapped offsets read 0. Writes to the read-only offsets 0x08, 0x0C and 0x18 change neither the mask nor the output latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 6 | Byte address within the bank window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Output latch towards the pads |
| pad_oe | output | 32 | Per-line output enable |

## Verification
The in-RTL assertions check on every cycle that:
- a configuration write leaves unselected lines untouched;
- the line chosen for a configuration read is the lowest selected one;
- set and clear writes move exactly the written latch bits, and the latch holds otherwise;
- a line's output enable follows the direction and function just written to it.

The field layout with its reserved zeros, the reset values, the two-edge input delay, the zero reads at the lock and unmapped offsets, and the immunity of state to writes at read-only offsets are shown only by the bench's scenarios. These run through the bus and compare read data and pad outputs against values worked out from the requirements.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  localparam int unsigned WORD_W = 32;

  // word index = byte offset / 4
  localparam logic [3:0] WIX_MASK = 4'd0;
  localparam logic [3:0] WIX_CFG  = 4'd1;
  localparam logic [3:0] WIX_PAD  = 4'd2;
  localparam logic [3:0] WIX_LOCK = 4'd3;
  localparam logic [3:0] WIX_SET  = 4'd4;
  localparam logic [3:0] WIX_CLR  = 4'd5;
  localparam logic [3:0] WIX_OUT  = 4'd6;

  typedef struct packed {
    logic [2:0] evt;
    logic       schmitt;
    logic       odrain;
    logic       slow_flt;
    logic       flt;
    logic       pdn;
    logic       pup;
    logic       dir;
    logic [2:0] func;
  } line_cfg_t;

  function automatic line_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    line_cfg_t c;
    c.func     = w[2:0];
    c.dir      = w[8];
    c.pup      = w[9];
    c.pdn      = w[10];
    c.flt      = w[12];
    c.slow_flt = w[13];
    c.odrain   = w[14];
    c.schmitt  = w[15];
    c.evt      = w[26:24];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input line_cfg_t c);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[2:0]   = c.func;
    w[8]     = c.dir;
    w[9]     = c.pup;
    w[10]    = c.pdn;
    w[12]    = c.flt;
    w[13]    = c.slow_flt;
    w[14]    = c.odrain;
    w[15]    = c.schmitt;
    w[26:24] = c.evt;
    return w;
  endfunction

endpackage

// File: rtl/gpb_cfg_store.sv
module gpb_cfg_store
  import gpb_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en,
  input  logic [LINES-1:0] sel_mask,
  input  line_cfg_t        wr_cfg,
  output line_cfg_t        cfg_q [LINES]
);

  line_cfg_t cfg_d [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic upd;
    assign upd = wr_en & sel_mask[i];

    always_comb begin
      cfg_d[i] = cfg_q[i];
      if (upd) cfg_d[i] = wr_cfg;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  cfg_q[i] <= '0;
      else if (upd) cfg_q[i] <= cfg_d[i];
    end

    AST_UNSEL_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
      !(wr_en && sel_mask[i]) |=> $stable(cfg_q[i])); // R2
  end

endmodule

// File: rtl/gpb_low_pick.sv
module gpb_low_pick #(
  parameter int unsigned LINES = 32,
  localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [LINES-1:0] mask,
  output logic [IDX_W-1:0] idx,
  output logic             hit
);

  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (mask[k]) begin
        idx = IDX_W'(k);
        hit = 1'b1;
      end
    end
  end

  logic [LINES-1:0] below;
  assign below = mask & ((LINES'(1) << idx) - LINES'(1));

  AST_PICK_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_ni)
    hit |-> (mask[idx] && (below == '0))); // R6

endmodule

// File: rtl/gpb_out_ctrl.sv
module gpb_out_ctrl #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [LINES-1:0] bits,
  input  logic [LINES-1:0] dir_out,
  input  logic [LINES-1:0] is_gpio,
  output logic [LINES-1:0] latch_q,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe
);

  logic [LINES-1:0] latch_d;
  logic             latch_ce;

  assign latch_ce = set_en | clr_en;

  always_comb begin
    latch_d = latch_q;
    if (set_en)      latch_d = latch_q | bits;
    else if (clr_en) latch_d = latch_q & ~bits;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       latch_q <= '0;
    else if (latch_ce) latch_q <= latch_d;
  end

  assign pad_out = latch_q;
  assign pad_oe  = dir_out & is_gpio;

  AST_SET_WRITES_ONES: assert property (@(posedge clk) disable iff (!rst_ni)
    set_en |=> ((latch_q & $past(bits)) == $past(bits))); // R4
  AST_CLR_WRITES_ZEROS: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_en |=> ((latch_q & $past(bits)) == '0)); // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!set_en && !clr_en) |=> $stable(latch_q)); // R4

endmodule

// File: rtl/gpb_pad_sync.sv
module gpb_pad_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
  import gpb_pkg::*;
#(
  parameter int unsigned LINES  = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe
);

  localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  logic [3:0] wix;
  assign wix = 4'(bus_addr[ADDR_W-1:2]);

  logic wr_mask_en, wr_cfg_en, wr_set_en, wr_clr_en;
  assign wr_mask_en = bus_wr && (wix == WIX_MASK);
  assign wr_cfg_en  = bus_wr && (wix == WIX_CFG);
  assign wr_set_en  = bus_wr && (wix == WIX_SET);
  assign wr_clr_en  = bus_wr && (wix == WIX_CLR);

  logic [LINES-1:0] mask_q, mask_d;
  always_comb begin
    mask_d = mask_q;
    if (wr_mask_en) mask_d = bus_wdata[LINES-1:0];
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)         mask_q <= '0;
    else if (wr_mask_en) mask_q <= mask_d;
  end

  line_cfg_t cfg_q [LINES];
  gpb_cfg_store #(.LINES(LINES)) u_store (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .wr_en    (wr_cfg_en),
    .sel_mask (mask_q),
    .wr_cfg   (word_to_cfg(bus_wdata)),
    .cfg_q    (cfg_q)
  );

  logic [IDX_W-1:0] pick_idx;
  logic             pick_hit;
  gpb_low_pick #(.LINES(LINES)) u_pick (
    .clk    (clk),
    .rst_ni (rst_ni),
    .mask   (mask_q),
    .idx    (pick_idx),
    .hit    (pick_hit)
  );

  logic [LINES-1:0] dir_vec, gpio_vec;
  for (genvar i = 0; i < LINES; i++) begin : g_flags
    assign dir_vec[i]  = cfg_q[i].dir;
    assign gpio_vec[i] = (cfg_q[i].func == 3'd0);
  end

  logic [LINES-1:0] latch_q;
  gpb_out_ctrl #(.LINES(LINES)) u_out (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .set_en  (wr_set_en),
    .clr_en  (wr_clr_en),
    .bits    (bus_wdata[LINES-1:0]),
    .dir_out (dir_vec),
    .is_gpio (gpio_vec),
    .latch_q (latch_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  logic [LINES-1:0] pad_lvl;
  gpb_pad_sync #(.W(LINES), .STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .d      (pad_in),
    .q      (pad_lvl)
  );

  always_comb begin
    bus_rdata = '0;
    case (wix)
      WIX_MASK: bus_rdata = WORD_W'(mask_q);
      WIX_CFG:  if (pick_hit) bus_rdata = cfg_to_word(cfg_q[pick_idx]);
      WIX_PAD:  bus_rdata = WORD_W'(pad_lvl);
      WIX_OUT:  bus_rdata = WORD_W'(latch_q);
      default:  bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    AST_OE_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rst_ni)
      (wr_cfg_en && mask_q[i]) |=>
        (pad_oe[i] == ($past(bus_wdata[8]) && ($past(bus_wdata[2:0]) == 3'd0)))); // R8
  end

endmodule

// File: tb/gpb_bank_tb.sv
module gpb_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  always #2 clk = ~clk; // 250 MHz

  gpb_bank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic mon_req = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  localparam logic [5:0] A_MASK = 6'h00, A_CFG = 6'h04, A_PAD = 6'h08,
                         A_LOCK = 6'h0C, A_SET = 6'h10, A_CLR = 6'h14,
                         A_OUT  = 6'h18, A_HOLE = 6'h3C;
  localparam logic [31:0] CFG_ALL = 32'h0700_F707;

  // monitor: pop expected item, compare with read data
  always @(negedge clk) begin
    if (mon_req) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read data %h, expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    mon_req = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = a; mon_req = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    bus_wr = 1'b0; mon_req = 1'b0;
  endtask

  task automatic chk_port(input string t, input logic [31:0] act, input logic [31:0] e);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: port value %h, expected %h", t, act, e);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(A_MASK, 32'h0, "R1 mask");
    rd(A_CFG,  32'h0, "R1 cfg");
    rd(A_OUT,  32'h0, "R1 latch");
    @(negedge clk); chk_port("R1 pad_oe", pad_oe, 32'h0);

    // R2 mask and selective update, R3 field layout
    wr(A_MASK, 32'h0000_0005);
    rd(A_MASK, 32'h0000_0005, "R2 mask readback");
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, CFG_ALL, "R3 implemented bits only");
    wr(A_MASK, 32'h0000_0002);
    rd(A_CFG, 32'h0, "R2 unselected line untouched");
    wr(A_MASK, 32'h0000_0004);
    rd(A_CFG, CFG_ALL, "R2 selected line 2 written");
    @(negedge clk); chk_port("R8 peripheral output not driven", pad_oe, 32'h0);

    // R8 GPIO output on line 2, R6 lowest line wins
    wr(A_CFG, 32'h0000_0100);
    rd(A_CFG, 32'h0000_0100, "R3 direction bit");
    @(negedge clk); chk_port("R8 gpio output driven", pad_oe, 32'h0000_0004);
    wr(A_MASK, 32'h0000_0005);
    rd(A_CFG, CFG_ALL, "R6 lowest of lines 0,2");
    wr(A_MASK, 32'h0000_0006);
    rd(A_CFG, 32'h0, "R6 lowest of lines 1,2");
    wr(A_MASK, 32'h8000_0000);
    wr(A_CFG, 32'h0100_0101);
    rd(A_CFG, 32'h0100_0101, "R3 event field top line");
    @(negedge clk); chk_port("R8 func 1 not driven", pad_oe, 32'h0000_0004);

    // R4 / R5 output latch
    wr(A_SET, 32'hF0F0_0004);
    rd(A_OUT, 32'hF0F0_0004, "R4 set");
    @(negedge clk); chk_port("R5 pad_out", pad_out, 32'hF0F0_0004);
    wr(A_SET, 32'h0000_0001);
    rd(A_OUT, 32'hF0F0_0005, "R4 set zeros keep");
    wr(A_CLR, 32'hF000_0004);
    rd(A_OUT, 32'h00F0_0001, "R4 clear");
    @(negedge clk); chk_port("R5 pad_out after clear", pad_out, 32'h00F0_0001);

    // R9 read-only and unmapped offsets
    wr(A_LOCK, 32'hFFFF_FFFF);
    wr(A_OUT,  32'hFFFF_FFFF);
    wr(A_PAD,  32'hFFFF_FFFF);
    rd(A_OUT,  32'h00F0_0001, "R9 latch unchanged");
    rd(A_MASK, 32'h8000_0000, "R9 mask unchanged");
    rd(A_LOCK, 32'h0, "R9 lock reads zero");
    rd(A_HOLE, 32'h0, "R9 unmapped reads zero");

    // R7 two-edge pad synchronizer
    idle();
    pad_in = 32'hA5A5_1234;
    rd(A_PAD, 32'h0, "R7 one edge not visible");
    rd(A_PAD, 32'hA5A5_1234, "R7 two edges visible");

    // R6 zero mask
    wr(A_MASK, 32'h0);
    rd(A_CFG, 32'h0, "R6 zero mask reads zero");
    idle();
    idle();
    finish_run();
  end

endmodule